// File: doc/BRIEF.md
# Multi-Hart Machine Timer Comparator

This block is the machine-timer unit of a small multi-core system. It keeps one shared 64-bit time counter and, for each hart, one 64-bit compare value. Each hart gets its own timer-interrupt line. The line is high while that hart's compare value is less than or equal to the current time. Software reaches every compare value and the time counter through a simple register bus. The bus takes 8-byte accesses and 32-bit accesses to either half of a 64-bit register.

Compare slots are 8 bytes wide, and the slot address carries an absolute hart ID. The slot used is that ID minus a configurable base hart ID, so a unit that serves harts 2 to 5 answers only at the slot addresses of those IDs. The time counter sits at its own 8-byte-aligned offset above the compare array. It advances by one on every cycle in which the tick-enable input is high. Software may write it, including moving it backwards, and every interrupt then follows the new time on the next cycle.

Top module: `hart_timer_unit`

## Requirements
- R1: The compare register of hart ID h sits at byte offset 8*h from BASE_ADDR. Only IDs from BASE_HART_ID to BASE_HART_ID+NUM_HARTS-1 are served, and they map to interrupt bits 0 to NUM_HARTS-1 in order.
- R2: An 8-byte access (req_size64=1) at offset 0 within a slot writes all 64 bits, or returns all 64 bits on rsp_rdata.
- R3: A 32-bit write at offset 0 replaces bits 31:0 and keeps bits 63:32. A 32-bit write at offset 4 replaces bits 63:32 with req_wdata[31:0] and keeps bits 31:0.
- R4: A 32-bit read at offset 0 returns bits 31:0 of the register on rsp_rdata[31:0]. A 32-bit read at offset 4 returns bits 63:32 there. Upper rsp_rdata bits are zero for 32-bit reads.
- R5: irq[i] is high in the cycle after a cycle in which compare[i] <= time holds, and low in the cycle after a cycle in which it does not. The interrupt therefore rises one cycle after a past compare value is written, or one cycle after time reaches the compare value.
- R6: The time counter increases by one at every clock edge where tick_en is high and no time write occurs. It wraps from all ones to zero.
- R7: The time counter sits at offset TIME_OFFSET (8-byte aligned) and accepts the same full and half accesses as a compare register. A time write wins over a tick in the same cycle.
- R8: After a time write, every interrupt is recomputed against the new time on the next edge. A backwards move clears interrupts whose compare value now lies in the future.
- R9: While rst is high, all compare registers and the time counter are zero, and irq and rsp_ready are low.
- R10: An access is ignored if any of these holds: the hart ID is out of range, the address is outside the window, the offset is not 0 or 4, or it is an 8-byte access at offset 4. An ignored access changes no register, and a read of it returns zero.
- R11: rsp_ready is high for exactly the one cycle after each cycle with req_valid high, for reads and writes alike, including ignored ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Advance the time counter this cycle |
| req_valid | input | 1 | Bus request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size64 | input | 1 | 1 = 8-byte access, 0 = 32-bit access |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 64 | Write data (low 32 bits used for 32-bit writes) |
| rsp_ready | output | 1 | Response strobe, one cycle after the request |
| rsp_rdata | output | 64 | Read data, valid with rsp_ready |
| irq | output | NUM_HARTS | Timer interrupt per served hart |

## Verification
The assertions assume that a request is a single-cycle pulse on req_valid, sampled at the clock edge with its fields stable. They also assume that tick_en is the only way the time counter moves besides a decoded time write. The bench drives every input at the falling edge and holds req_valid low through reset. It keeps tick_en low except in the windows where a tick is the point of the test, so every expected time and interrupt value follows from the writes alone.

// File: rtl/htu_pkg.sv
package htu_pkg;

  typedef enum logic [1:0] {
    ACC_NONE = 2'd0,
    ACC_LO   = 2'd1,
    ACC_HI   = 2'd2,
    ACC_FULL = 2'd3
  } acc_kind_e;

  function automatic logic [63:0] merge64(input logic [63:0] old_v,
                                          input logic [63:0] new_v,
                                          input acc_kind_e   k);
    case (k)
      ACC_FULL: return new_v;
      ACC_LO:   return {old_v[63:32], new_v[31:0]};
      ACC_HI:   return {new_v[31:0], old_v[31:0]};
      default:  return old_v;
    endcase
  endfunction

  function automatic logic [63:0] read_slice(input logic [63:0] v,
                                             input acc_kind_e   k);
    case (k)
      ACC_FULL: return v;
      ACC_LO:   return {32'd0, v[31:0]};
      ACC_HI:   return {32'd0, v[63:32]};
      default:  return 64'd0;
    endcase
  endfunction

endpackage

// File: rtl/htu_decode.sv
module htu_decode
  import htu_pkg::*;
#(
  parameter int                ADDR_W       = 32,
  parameter logic [ADDR_W-1:0] BASE_ADDR    = '0,
  parameter int                WINDOW_BYTES = 32768,
  parameter int                TIME_OFFSET  = 32760,
  parameter int                NUM_HARTS    = 4,
  parameter int                BASE_HART_ID = 0,
  parameter int                IDX_W        = 2
) (
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_size64,
  output logic              cmp_hit,
  output logic              time_hit,
  output logic [IDX_W-1:0]  idx,
  output acc_kind_e         kind
);

  localparam int              ID_W      = ADDR_W - 3;
  localparam logic [ID_W-1:0] FIRST_ID  = ID_W'(BASE_HART_ID);
  localparam logic [ID_W-1:0] LAST_ID   = ID_W'(BASE_HART_ID + NUM_HARTS - 1);
  localparam logic [ID_W-1:0] TIME_SLOT = ID_W'(TIME_OFFSET / 8);

  logic [ADDR_W-1:0] loc_off;
  logic [ID_W-1:0]   slot_id;
  logic              in_win;
  logic              is_time;

  always_comb begin
    loc_off = req_addr - BASE_ADDR;
    slot_id = loc_off[ADDR_W-1:3];
    in_win  = (req_addr >= BASE_ADDR) && (loc_off < ADDR_W'(WINDOW_BYTES));
    is_time = (slot_id == TIME_SLOT);

    case ({req_size64, loc_off[2:0]})
      4'b0_000: kind = ACC_LO;
      4'b0_100: kind = ACC_HI;
      4'b1_000: kind = ACC_FULL;
      default:  kind = ACC_NONE;
    endcase

    time_hit = in_win && is_time && (kind != ACC_NONE);
    cmp_hit  = in_win && !is_time && (kind != ACC_NONE) &&
               (slot_id >= FIRST_ID) && (slot_id <= LAST_ID);
    idx      = IDX_W'(slot_id - FIRST_ID);
  end

endmodule

// File: rtl/htu_time_counter.sv
module htu_time_counter
  import htu_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        tick_en,
  input  logic        wr_en,
  input  acc_kind_e   kind,
  input  logic [63:0] wdata,
  output logic [63:0] time_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      time_q <= 64'd0;
    end else if (wr_en) begin
      time_q <= merge64(time_q, wdata, kind);
    end else if (tick_en) begin
      time_q <= time_q + 64'd1;
    end
  end

  AST_TIME_STEP: assert property (@(posedge clk) disable iff (rst)
    (!wr_en && tick_en) |=> (time_q == $past(time_q) + 64'd1)); // R6

  AST_TIME_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!wr_en && !tick_en) |=> $stable(time_q)); // R6

  AST_TIME_RESET: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (time_q == 64'd0)); // R9

endmodule

// File: rtl/htu_compare_bank.sv
module htu_compare_bank
  import htu_pkg::*;
#(
  parameter int NUM_HARTS = 4,
  parameter int IDX_W     = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    wr_en,
  input  logic [IDX_W-1:0]        idx,
  input  acc_kind_e               kind,
  input  logic [63:0]             wdata,
  input  logic [63:0]             time_q,
  output logic [63:0]             rd_val,
  output logic [NUM_HARTS*64-1:0] cmp_flat,
  output logic [NUM_HARTS-1:0]    irq
);

  logic [63:0] cmp_q [NUM_HARTS];

  for (genvar g = 0; g < NUM_HARTS; g++) begin : g_hart
    logic sel;
    assign sel = wr_en && (idx == IDX_W'(g));

    always_ff @(posedge clk) begin
      if (rst) begin
        cmp_q[g] <= 64'd0;
        irq[g]   <= 1'b0;
      end else begin
        if (sel) cmp_q[g] <= merge64(cmp_q[g], wdata, kind);
        irq[g] <= (cmp_q[g] <= time_q);
      end
    end

    assign cmp_flat[g*64 +: 64] = cmp_q[g];

    AST_LO_WRITE_KEEPS_HI: assert property (@(posedge clk) disable iff (rst)
      (sel && kind == ACC_LO) |=> (cmp_q[g][63:32] == $past(cmp_q[g][63:32]))); // R3

    AST_HI_WRITE_KEEPS_LO: assert property (@(posedge clk) disable iff (rst)
      (sel && kind == ACC_HI) |=> (cmp_q[g][31:0] == $past(cmp_q[g][31:0]))); // R3
  end

  assign rd_val = cmp_q[idx];

endmodule

// File: rtl/hart_timer_unit.sv
module hart_timer_unit
  import htu_pkg::*;
#(
  parameter int                ADDR_W       = 32,
  parameter logic [ADDR_W-1:0] BASE_ADDR    = 32'h0200_0000,
  parameter int                WINDOW_BYTES = 32768,
  parameter int                TIME_OFFSET  = 32760,
  parameter int                MAX_HARTS    = 16,
  parameter int                NUM_HARTS    = 4,
  parameter int                BASE_HART_ID = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 tick_en,
  input  logic                 req_valid,
  input  logic                 req_write,
  input  logic                 req_size64,
  input  logic [ADDR_W-1:0]    req_addr,
  input  logic [63:0]          req_wdata,
  output logic                 rsp_ready,
  output logic [63:0]          rsp_rdata,
  output logic [NUM_HARTS-1:0] irq
);

  localparam int IDX_W = (NUM_HARTS > 1) ? $clog2(NUM_HARTS) : 1;

  if (NUM_HARTS > MAX_HARTS) begin : g_chk_harts
    $error("NUM_HARTS exceeds MAX_HARTS");
  end
  if (BASE_ADDR[2:0] != 3'b000) begin : g_chk_base
    $error("BASE_ADDR must be 8-byte aligned");
  end
  if ((TIME_OFFSET % 8) != 0 || TIME_OFFSET < 8 * (BASE_HART_ID + NUM_HARTS) ||
      TIME_OFFSET + 8 > WINDOW_BYTES) begin : g_chk_time
    $error("TIME_OFFSET must be aligned, above the compare array and inside the window");
  end

  logic                    cmp_hit;
  logic                    time_hit;
  logic [IDX_W-1:0]        idx;
  acc_kind_e               kind;
  logic [63:0]             time_q;
  logic [63:0]             cmp_rd;
  logic [NUM_HARTS*64-1:0] cmp_flat;
  logic                    wr_fire;
  logic [63:0]             rd_mux;

  htu_decode #(
    .ADDR_W      (ADDR_W),
    .BASE_ADDR   (BASE_ADDR),
    .WINDOW_BYTES(WINDOW_BYTES),
    .TIME_OFFSET (TIME_OFFSET),
    .NUM_HARTS   (NUM_HARTS),
    .BASE_HART_ID(BASE_HART_ID),
    .IDX_W       (IDX_W)
  ) u_decode (
    .req_addr  (req_addr),
    .req_size64(req_size64),
    .cmp_hit   (cmp_hit),
    .time_hit  (time_hit),
    .idx       (idx),
    .kind      (kind)
  );

  assign wr_fire = req_valid && req_write;

  htu_time_counter u_time (
    .clk    (clk),
    .rst    (rst),
    .tick_en(tick_en),
    .wr_en  (wr_fire && time_hit),
    .kind   (kind),
    .wdata  (req_wdata),
    .time_q (time_q)
  );

  htu_compare_bank #(
    .NUM_HARTS(NUM_HARTS),
    .IDX_W    (IDX_W)
  ) u_bank (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_fire && cmp_hit),
    .idx     (idx),
    .kind    (kind),
    .wdata   (req_wdata),
    .time_q  (time_q),
    .rd_val  (cmp_rd),
    .cmp_flat(cmp_flat),
    .irq     (irq)
  );

  always_comb begin
    if (time_hit)     rd_mux = read_slice(time_q, kind);
    else if (cmp_hit) rd_mux = read_slice(cmp_rd, kind);
    else              rd_mux = 64'd0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_ready <= 1'b0;
      rsp_rdata <= 64'd0;
    end else begin
      rsp_ready <= req_valid;
      rsp_rdata <= (req_valid && !req_write) ? rd_mux : 64'd0;
    end
  end

  AST_READY_PULSE: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (rsp_ready == $past(req_valid))); // R11

  AST_IGNORED_WRITE_NO_CHANGE: assert property (@(posedge clk) disable iff (rst)
    (wr_fire && !cmp_hit && !time_hit) |=>
      ($stable(cmp_flat) && time_q == $past(time_q) + 64'($past(tick_en)))); // R10

  AST_IGNORED_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_write && !cmp_hit && !time_hit) |=> (rsp_rdata == 64'd0)); // R10

endmodule

// File: tb/hart_timer_unit_test.sv
module hart_timer_unit_test;

  localparam logic [31:0] BA    = 32'h0200_0000;
  localparam logic [31:0] TADDR = BA + 32'h7FF8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick_en = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic        req_size64 = 1'b0;
  logic [31:0] req_addr = '0;
  logic [63:0] req_wdata = '0;
  logic        rsp_ready;
  logic [63:0] rsp_rdata;
  logic [3:0]  irq;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  hart_timer_unit uut (
    .clk(clk), .rst(rst), .tick_en(tick_en),
    .req_valid(req_valid), .req_write(req_write), .req_size64(req_size64),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata), .irq(irq)
  );

  function automatic logic [31:0] slot(input int hart_id);
    return BA + 32'(8 * hart_id);
  endfunction

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic access(input logic wr, input logic sz64, input logic [31:0] addr,
                        input logic [63:0] wd, output logic [63:0] rd);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_size64 = sz64;
    req_addr = addr; req_wdata = wd;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
    chk("R11 ready after request", 64'(rsp_ready), 64'd1);
    rd = rsp_rdata;
  endtask

  task automatic wr(input logic sz64, input logic [31:0] addr, input logic [63:0] wd);
    logic [63:0] unused_rd;
    access(1'b1, sz64, addr, wd, unused_rd);
  endtask

  task automatic rd(input logic sz64, input logic [31:0] addr, output logic [63:0] v);
    access(1'b0, sz64, addr, 64'd0, v);
  endtask

  task automatic settle();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R9 irq low in reset", 64'(irq), 64'd0);
    chk("R9 ready low in reset", 64'(rsp_ready), 64'd0);
    rst = 1'b0;
    settle();
    chk("R5 irq after reset, compare 0 <= time 0", 64'(irq), 64'hF);
    chk("R11 ready idle", 64'(rsp_ready), 64'd0);
  endtask

  task automatic t_reset_values();
    logic [63:0] v;
    rd(1'b1, TADDR, v);
    chk("R9 time zero", v, 64'd0);
    rd(1'b1, slot(4), v);
    chk("R9 compare zero", v, 64'd0);
  endtask

  task automatic t_full_and_halves();
    logic [63:0] v;
    wr(1'b1, slot(3), 64'h1122_3344_5566_7788);
    rd(1'b1, slot(3), v);
    chk("R2 full read back", v, 64'h1122_3344_5566_7788);
    rd(1'b0, slot(3), v);
    chk("R4 low half read", v, 64'h0000_0000_5566_7788);
    rd(1'b0, slot(3) + 32'd4, v);
    chk("R4 high half read", v, 64'h0000_0000_1122_3344);
    wr(1'b0, slot(3), 64'hFFFF_FFFF_AAAA_BBBB);
    rd(1'b1, slot(3), v);
    chk("R3 low write keeps high", v, 64'h1122_3344_AAAA_BBBB);
    wr(1'b0, slot(3) + 32'd4, 64'h0000_0000_CCCC_DDDD);
    rd(1'b1, slot(3), v);
    chk("R3 high write keeps low", v, 64'hCCCC_DDDD_AAAA_BBBB);
  endtask

  task automatic t_ignored();
    logic [63:0] v;
    wr(1'b1, slot(1), 64'h0000_0000_0000_0777);
    wr(1'b1, slot(6), 64'h0000_0000_0000_0777);
    wr(1'b0, slot(3) + 32'd2, 64'h0000_0000_0000_0777);
    wr(1'b1, slot(3) + 32'd4, 64'h0000_0000_0000_0777);
    wr(1'b1, BA - 32'd8, 64'h0000_0000_0000_0777);
    rd(1'b1, slot(3), v);
    chk("R10 hart 3 unchanged", v, 64'hCCCC_DDDD_AAAA_BBBB);
    rd(1'b1, slot(2), v);
    chk("R1 hart 2 untouched by id 1 write", v, 64'd0);
    rd(1'b1, slot(5), v);
    chk("R1 hart 5 untouched by id 6 write", v, 64'd0);
    rd(1'b1, TADDR, v);
    chk("R10 time unchanged", v, 64'd0);
    rd(1'b1, slot(1), v);
    chk("R10 out-of-range read zero", v, 64'd0);
    rd(1'b0, slot(3) + 32'd6, v);
    chk("R10 bad offset read zero", v, 64'd0);
    settle();
    chk("R10 irq unchanged", 64'(irq), 64'hD);
  endtask

  task automatic t_compare();
    wr(1'b1, TADDR, 64'd100);
    wr(1'b1, slot(2), 64'd100);
    wr(1'b1, slot(3), 64'd101);
    wr(1'b1, slot(4), 64'd50);
    wr(1'b1, slot(5), 64'hFFFF_FFFF_0000_0000);
    settle();
    chk("R5 equal and past raise, future low", 64'(irq), 64'h5);
    tick_en = 1'b1;
    @(posedge clk);
    @(negedge clk);
    tick_en = 1'b0;
    chk("R5 no raise in the tick cycle", 64'(irq), 64'h5);
    settle();
    chk("R5 raise one cycle after time reaches compare", 64'(irq), 64'h7);
  endtask

  task automatic t_time_writes();
    logic [63:0] v;
    wr(1'b1, TADDR, 64'd0);
    settle();
    chk("R8 backwards time clears", 64'(irq), 64'h0);
    wr(1'b0, TADDR + 32'd4, 64'd1);
    rd(1'b1, TADDR, v);
    chk("R7 time high-half write", v, 64'h0000_0001_0000_0000);
    rd(1'b0, TADDR + 32'd4, v);
    chk("R7 time high-half read", v, 64'd1);
    chk("R8 forward time raises", 64'(irq), 64'h7);
    @(negedge clk);
    tick_en = 1'b1; req_valid = 1'b1; req_write = 1'b1; req_size64 = 1'b1;
    req_addr = TADDR; req_wdata = 64'h500;
    @(posedge clk);
    @(negedge clk);
    tick_en = 1'b0; req_valid = 1'b0; req_write = 1'b0;
    rd(1'b1, TADDR, v);
    chk("R7 write wins over tick", v, 64'h500);
  endtask

  task automatic t_ticks();
    logic [63:0] v;
    wr(1'b1, TADDR, 64'h20);
    @(negedge clk);
    tick_en = 1'b1;
    repeat (10) @(posedge clk);
    @(negedge clk);
    tick_en = 1'b0;
    rd(1'b1, TADDR, v);
    chk("R6 ten ticks", v, 64'h2A);
    wr(1'b1, TADDR, 64'hFFFF_FFFF_FFFF_FFFF);
    @(negedge clk);
    tick_en = 1'b1;
    @(posedge clk);
    @(negedge clk);
    tick_en = 1'b0;
    rd(1'b1, TADDR, v);
    chk("R6 wrap to zero", v, 64'd0);
    @(negedge clk);
    chk("R11 ready one cycle only", 64'(rsp_ready), 64'd0);
  endtask

  initial begin
    t_reset();
    t_reset_values();
    t_full_and_halves();
    t_ignored();
    t_compare();
    t_time_writes();
    t_ticks();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired got=%0d exp=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule